// File: doc/BRIEF.md
# Row Hit Sampler and Bank Encoder

This block watches a row of 42 asynchronous pixel hit pulses and turns them into compact write requests for a row memory. Each hit line first passes through a two-flop synchronizer. On each sample strobe the synchronized row is latched into one of two alternating capture stages. While the next sample is being gathered, the stage just filled is scanned, so sampling has no dead time.

The scan runs on the fast clock, eight slots per sample period. The slot counter is turned into a 3-bit Gray-coded address. Address 0 is a deselect slot. Addresses 1 to 7 each pick one bank of six neighbouring pixels. When the selected bank holds a hit, the block raises a write request for that slot. The request carries the bank's 6-bit pattern, the bank address and a 13-bit sample timestamp. An override input forces a write for every bank, including empty ones.

The sample strobe is a one-cycle pulse in the scan clock domain and is expected every eight cycles.

Top module: `row_hit_bank_scanner`

## Requirements
- R1: After reset, `wr_req_o` is 0 and `scan_addr_o` is 0.
- R2: In the eight cycles after a strobe edge, `scan_addr_o` runs 0,1,3,2,6,7,5,4. Consecutive addresses always differ in at most one bit.
- R3: No write is requested while the address is 0, whether or not override is set.
- R4: With override low, a slot with address a (1..7) requests a write only if at least one of hit bits 6(a-1) to 6(a-1)+5 was captured.
- R5: The write word holds the pattern in bits [5:0], where bit j is pixel 6(a-1)+j. The address sits in bits [8:6] and the timestamp in bits [21:9].
- R6: The first sample after reset carries timestamp 0. Each strobe adds one, and the count wraps from 8191 to 0.
- R7: With override high, all seven bank slots request a write, even when their pattern is zero.
- R8: A hit held high across two consecutive strobes is reported in both scans, with consecutive timestamps.
- R9: A hit is captured only if it was high at the clock edge two cycles before the strobe edge. A hit that rises later falls into the next sample.
- R10: Changes on the hit inputs during a scan do not alter the pattern or timestamp reported in that scan.
- R11: If no further strobe comes, the scan stops after one pass. The address then returns to 0 and no writes are requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast scan clock, eight cycles per sample |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hit_i | input | 42 | Asynchronous pixel hit pulses |
| sample_i | input | 1 | One-cycle sample strobe |
| override_i | input | 1 | Write every bank regardless of hits |
| wr_req_o | output | 1 | Write request for the current slot |
| wr_data_o | output | 22 | {timestamp, bank address, pattern} |
| scan_addr_o | output | 3 | Gray-coded bank address being scanned |

## Verification
A single hit in the first bank pins down the pattern bit order and the slot order. A sparse row spread over three banks, including the last one, shows that only occupied banks write, and each in its own Gray slot. An empty row without override shows that nothing is written. The same empty row with override shows forced writes with zero patterns and no write in the deselect slot. A hit held across two strobes, a hit raised one cycle too late, a row changed halfway through a scan, and a run of strobes that reaches the timestamp wrap cover double capture, synchronizer latency, stage isolation and counter roll-over.

// File: rtl/rhb_pkg.sv
`timescale 1ns/1ps
package rhb_pkg;
   localparam int unsigned RHB_BANKS     = 7;
   localparam int unsigned RHB_BANK_W    = 6;
   localparam int unsigned RHB_ADDR_W    = 3;
   localparam int unsigned RHB_TS_W      = 13;
   localparam int unsigned RHB_SYNC_DEPTH = 2;
endpackage

// File: rtl/rhb_hit_sync.sv
`timescale 1ns/1ps
module rhb_hit_sync #(
   parameter int unsigned W      = 42,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_depth
      $error("rhb_hit_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[s] <= '0;
            else         chain_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[s] <= '0;
            else         chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rhb_capture_pingpong.sv
`timescale 1ns/1ps
module rhb_capture_pingpong #(
   parameter int unsigned W    = 42,
   parameter int unsigned TS_W = 13
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            sample_i,
   input  logic [W-1:0]    row_i,
   output logic [W-1:0]    scan_row_o,
   output logic [TS_W-1:0] scan_ts_o
);
   logic [W-1:0]    stage_row_q [2];
   logic [TS_W-1:0] stage_ts_q  [2];
   logic            fill_sel_q;
   logic [TS_W-1:0] ts_q;

   for (genvar s = 0; s < 2; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            stage_row_q[s] <= '0;
            stage_ts_q[s]  <= '0;
         end else if (sample_i && (fill_sel_q == 1'(s))) begin
            stage_row_q[s] <= row_i;
            stage_ts_q[s]  <= ts_q;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fill_sel_q <= 1'b0;
         ts_q       <= '0;
      end else if (sample_i) begin
         fill_sel_q <= ~fill_sel_q;
         ts_q       <= ts_q + TS_W'(1);
      end
   end

   // The stage not being filled is the one most recently captured.
   assign scan_row_o = fill_sel_q ? stage_row_q[0] : stage_row_q[1];
   assign scan_ts_o  = fill_sel_q ? stage_ts_q[0]  : stage_ts_q[1];

   // R10
   hold_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sample_i |=> $stable(scan_row_o));
   // R10
   hold_ts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sample_i |=> $stable(scan_ts_o));
endmodule

// File: rtl/rhb_bank_scanner.sv
`timescale 1ns/1ps
module rhb_bank_scanner #(
   parameter int unsigned BANKS  = 7,
   parameter int unsigned BANK_W = 6,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned TS_W   = 13,
   localparam int unsigned ROW_W  = BANKS * BANK_W,
   localparam int unsigned SLOTS  = 1 << ADDR_W,
   localparam int unsigned WORD_W = TS_W + ADDR_W + BANK_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sample_i,
   input  logic              override_i,
   input  logic [ROW_W-1:0]  row_i,
   input  logic [TS_W-1:0]   ts_i,
   output logic              wr_req_o,
   output logic [WORD_W-1:0] wr_data_o,
   output logic [ADDR_W-1:0] addr_o
);
   if (BANKS != SLOTS - 1) begin : g_bad_banks
      $error("rhb_bank_scanner: BANKS must equal 2**ADDR_W - 1");
   end

   logic [ADDR_W-1:0] slot_q;
   logic              active_q;
   logic [BANK_W-1:0] pattern;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         slot_q   <= '0;
         active_q <= 1'b0;
      end else if (sample_i) begin
         slot_q   <= '0;
         active_q <= 1'b1;
      end else if (active_q) begin
         if (slot_q == ADDR_W'(SLOTS - 1)) active_q <= 1'b0;
         else                              slot_q   <= slot_q + ADDR_W'(1);
      end
   end

   assign addr_o = active_q ? (slot_q ^ (slot_q >> 1)) : '0;

   always_comb begin
      pattern = '0;
      for (int b = 0; b < int'(BANKS); b++) begin
         if (addr_o == ADDR_W'(b + 1)) pattern = row_i[b*BANK_W +: BANK_W];
      end
   end

   assign wr_req_o  = (addr_o != '0) && (override_i || (|pattern));
   assign wr_data_o = {ts_i, addr_o, pattern};

   // R3
   no_deselect_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_req_o |-> (wr_data_o[BANK_W +: ADDR_W] != '0));
   // R4
   empty_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_req_o && !override_i) |-> (wr_data_o[BANK_W-1:0] != '0));
   // R2
   gray_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sample_i |=> ($countones(addr_o ^ $past(addr_o)) <= 1));
endmodule

// File: rtl/row_hit_bank_scanner.sv
`timescale 1ns/1ps
module row_hit_bank_scanner #(
   parameter int unsigned BANKS      = rhb_pkg::RHB_BANKS,
   parameter int unsigned BANK_W     = rhb_pkg::RHB_BANK_W,
   parameter int unsigned ADDR_W     = rhb_pkg::RHB_ADDR_W,
   parameter int unsigned TS_W       = rhb_pkg::RHB_TS_W,
   parameter int unsigned SYNC_DEPTH = rhb_pkg::RHB_SYNC_DEPTH,
   localparam int unsigned ROW_W  = BANKS * BANK_W,
   localparam int unsigned WORD_W = TS_W + ADDR_W + BANK_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ROW_W-1:0]  hit_i,
   input  logic              sample_i,
   input  logic              override_i,
   output logic              wr_req_o,
   output logic [WORD_W-1:0] wr_data_o,
   output logic [ADDR_W-1:0] scan_addr_o
);
   logic [ROW_W-1:0] synced_row;
   logic [ROW_W-1:0] scan_row;
   logic [TS_W-1:0]  scan_ts;

   rhb_hit_sync #(.W(ROW_W), .STAGES(SYNC_DEPTH)) sync_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(hit_i), .q_o(synced_row)
   );

   rhb_capture_pingpong #(.W(ROW_W), .TS_W(TS_W)) capture_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i),
      .row_i(synced_row), .scan_row_o(scan_row), .scan_ts_o(scan_ts)
   );

   rhb_bank_scanner #(.BANKS(BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .TS_W(TS_W)) scan_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i), .override_i(override_i),
      .row_i(scan_row), .ts_i(scan_ts),
      .wr_req_o(wr_req_o), .wr_data_o(wr_data_o), .addr_o(scan_addr_o)
   );

   // R11
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (scan_addr_o == '0) |-> !wr_req_o);
endmodule

// File: tb/row_hit_bank_scanner_tb.sv
`timescale 1ns/1ps
module row_hit_bank_scanner_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [41:0] hit = '0;
   logic        sample = 1'b0;
   logic        ovr = 1'b0;
   logic        wr_req;
   logic [21:0] wr_data;
   logic [2:0]  scan_addr;

   int checks = 0;
   int fails  = 0;
   int exp_ts = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   row_hit_bank_scanner dut_i (
      .clk_i(clk), .rst_ni(rst_n), .hit_i(hit), .sample_i(sample),
      .override_i(ovr), .wr_req_o(wr_req), .wr_data_o(wr_data), .scan_addr_o(scan_addr)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic set_hits(input logic [41:0] v);
      hit = v;
      repeat (2) @(negedge clk);
   endtask

   // Issue a strobe and check all eight slots of the following scan.
   task automatic do_sample(input logic [41:0] row, input bit o, input string tag,
                            input bit mid, input logic [41:0] mid_val);
      int ts_e;
      sample = 1'b1;
      ovr    = o;
      @(posedge clk);
      @(negedge clk);
      sample = 1'b0;
      ts_e   = exp_ts;
      exp_ts = (exp_ts + 1) % 8192;
      for (int k = 0; k < 8; k++) begin
         logic [2:0] a;
         logic [5:0] p;
         bit         req;
         if (k > 0) @(negedge clk);
         if (mid && k == 3) hit = mid_val;
         a   = 3'(k ^ (k >> 1));
         p   = (a == 0) ? 6'd0 : row[(int'(a) - 1) * 6 +: 6];
         req = (a != 0) && (o || (p != 0));
         chk(scan_addr == a, {tag, " R2 addr"}, 64'(scan_addr), 64'(a));
         chk(wr_req == req, {tag, " R4/R3/R7 req"}, 64'(wr_req), 64'(req));
         if (req)
            chk(wr_data == {13'(ts_e), a, p}, {tag, " R5/R6 data"}, 64'(wr_data), 64'({13'(ts_e), a, p}));
      end
   endtask

   task automatic quick_sample();
      sample = 1'b1;
      @(posedge clk);
      @(negedge clk);
      sample = 1'b0;
      exp_ts = (exp_ts + 1) % 8192;
   endtask

   task automatic t_reset();
      chk(wr_req == 1'b0, "R1 reset req", 64'(wr_req), 64'd0);
      chk(scan_addr == 3'd0, "R1 reset addr", 64'(scan_addr), 64'd0);
   endtask

   task automatic t_single();
      set_hits(42'h1);
      do_sample(42'h1, 0, "single R2 R5", 0, '0);
   endtask

   task automatic t_sparse();
      logic [41:0] v;
      v = '0;
      v[8]  = 1'b1;
      v[11] = 1'b1;
      v[27] = 1'b1;
      v[41] = 1'b1;
      v[36] = 1'b1;
      set_hits(v);
      do_sample(v, 0, "sparse R4", 0, '0);
   endtask

   task automatic t_empty();
      set_hits('0);
      do_sample('0, 0, "empty R4", 0, '0);
   endtask

   task automatic t_override();
      set_hits('0);
      do_sample('0, 1, "override R7 R3", 0, '0);
      ovr = 1'b0;
   endtask

   task automatic t_double();
      logic [41:0] v;
      v = 42'h3 << 18;
      set_hits(v);
      do_sample(v, 0, "double R8 first", 0, '0);
      do_sample(v, 0, "double R8 second", 0, '0);
   endtask

   task automatic t_late();
      logic [41:0] v;
      set_hits('0);
      v = 42'h20 << 24;
      hit = v;
      do_sample('0, 0, "late R9 missed", 0, '0);
      do_sample(v, 0, "late R9 next", 0, '0);
   endtask

   task automatic t_midscan();
      logic [41:0] v;
      v = 42'h15 << 30;
      set_hits(v);
      do_sample(v, 0, "midscan R10", 1, ~v);
   endtask

   task automatic t_idle();
      repeat (3) begin
         @(negedge clk);
         chk(scan_addr == 3'd0 && wr_req == 1'b0, "idle R11", {61'd0, scan_addr}, 64'd0);
      end
   endtask

   task automatic t_wrap();
      logic [41:0] v;
      set_hits('0);
      while (exp_ts != 8191) quick_sample();
      v = 42'h2A << 12;
      set_hits(v);
      do_sample(v, 0, "wrap R6 last", 0, '0);
      do_sample(v, 0, "wrap R6 zero", 0, '0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_sparse();
      t_empty();
      t_override();
      t_double();
      t_late();
      t_midscan();
      t_idle();
      t_wrap();
      t_idle();
      finish_run();
   end
endmodule